// File: doc/BRIEF.md
# DMA Descriptor Configuration Error Checker

This block sits next to a DMA transfer engine and judges whether the transfer descriptor of the active channel is self-consistent. When the engine issues a check strobe, the block looks at the destination address, destination offset, minor-loop byte count and the iteration counters. It compares them against the source and destination element sizes. When a major loop finishes with descriptor chaining switched on, the block also checks that the address of the next descriptor lies on a 32-byte boundary. The read and write paths report bus faults to it through single-cycle strobes.

Only the latest fault is kept. Any cycle in which at least one fault is detected overwrites the whole flag set with that cycle's findings, sets a valid bit and records the channel number. A write-one-to-clear input empties the record. The engine, the bus interface and the descriptor store all lie outside this block. The block receives only the low address and count bits that the rules need, plus the full current iteration count.

Top module: `dma_cfg_err_chk`

## Requirements
- R1: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes, and a value is aligned to a size when its low log2(size) bits are zero. On a check strobe, a destination address that is not aligned to the destination size sets the destination-address flag `err_dst_addr`.
- R2: On a check strobe, a destination offset that is not aligned to the destination size sets `err_dst_off`.
- R3: On a check strobe, a minor-loop byte count that is not aligned to both the source size and the destination size sets `err_cnt_iter`.
- R4: On a check strobe, `err_cnt_iter` is also set when the current iteration count is zero, or when the current and beginning link-enable bits differ.
- R5: The next-descriptor address is checked only when the major-done strobe and the chaining enable are both high. In that case, any nonzero bit among its low 5 bits sets `err_sg_addr`. Without both conditions, the address has no effect.
- R6: A read-fault strobe sets `err_src_bus`, and a write-fault strobe sets `err_dst_bus`.
- R7: In every cycle with at least one detected fault, all six flags are replaced by that cycle's detections. Detections in the same cycle are combined.
- R8: A fault cycle sets `err_valid` and loads `err_chan` with `chan_id`. A check strobe that finds no fault leaves the flags, `err_valid` and `err_chan` unchanged.
- R9: `clr_w1c` clears `err_valid` and all flags while `err_chan` holds its value. If a fault is detected in the same cycle, the fault is recorded and the clear is ignored.
- R10: All results appear at the outputs after the rising clock edge that samples the strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_id | input | 6 | Channel currently served |
| chk_start | input | 1 | Descriptor check strobe |
| src_size | input | 2 | Source size code |
| dst_size | input | 2 | Destination size code |
| dst_addr_lo | input | 3 | Low bits of destination address |
| dst_off_lo | input | 3 | Low bits of destination offset |
| nbytes_lo | input | 3 | Low bits of minor-loop byte count |
| cur_iter | input | 15 | Current major iteration count |
| cur_link_en | input | 1 | Link-enable bit of current count |
| beg_link_en | input | 1 | Link-enable bit of beginning count |
| major_done | input | 1 | Major loop completion strobe |
| sg_enable | input | 1 | Descriptor chaining enabled |
| sg_addr_lo | input | 5 | Low bits of next-descriptor address |
| rd_bus_err | input | 1 | Bus fault on source read |
| wr_bus_err | input | 1 | Bus fault on destination write |
| clr_w1c | input | 1 | Clear record (write one) |
| err_dst_addr | output | 1 | Destination address flag |
| err_dst_off | output | 1 | Destination offset flag |
| err_cnt_iter | output | 1 | Byte count / iteration flag |
| err_sg_addr | output | 1 | Next-descriptor address flag |
| err_src_bus | output | 1 | Source bus fault flag |
| err_dst_bus | output | 1 | Destination bus fault flag |
| err_valid | output | 1 | A fault is recorded |
| err_chan | output | 6 | Channel of recorded fault |

## Verification
Every result is due exactly one rising edge after its strobe. The strobe, the clear and the bus-fault inputs all pass through a single register stage. The bench drives each stimulus on a falling edge and holds it for one full cycle. It compares the outputs at the next falling edge, when the capturing edge has gone by. In one scenario it also samples shortly after applying the strobe, before the edge, to confirm that nothing has changed yet.

// File: rtl/dmachk_pkg.sv
package dmachk_pkg;

    localparam int CHAN_W   = 6;
    localparam int LOW_W    = 3;   // log2 of largest element (8 bytes)
    localparam int SGA_W    = 5;   // 32-byte descriptor boundary
    localparam int ITER_W   = 15;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic dst_addr;
        logic dst_off;
        logic cnt_iter;
        logic sg_addr;
        logic src_bus;
        logic dst_bus;
    } err_flags_t;

    localparam err_flags_t NO_ERR = '0;

    function automatic logic [LOW_W-1:0] size_mask(input xfer_size_e sz);
        logic [LOW_W-1:0] m;
        case (sz)
            SZ_1B:   m = 3'b000;
            SZ_2B:   m = 3'b001;
            SZ_4B:   m = 3'b011;
            default: m = 3'b111;
        endcase
        return m;
    endfunction

    function automatic logic not_aligned(input logic [LOW_W-1:0] v, input xfer_size_e sz);
        return |(v & size_mask(sz));
    endfunction

endpackage

// File: rtl/desc_rule_eval.sv
module desc_rule_eval
    import dmachk_pkg::*;
#(
    parameter int ITER_BITS = ITER_W
) (
    input  logic                 chk_start,
    input  xfer_size_e           src_size,
    input  xfer_size_e           dst_size,
    input  logic [LOW_W-1:0]     dst_addr_lo,
    input  logic [LOW_W-1:0]     dst_off_lo,
    input  logic [LOW_W-1:0]     nbytes_lo,
    input  logic [ITER_BITS-1:0] cur_iter,
    input  logic                 cur_link_en,
    input  logic                 beg_link_en,
    output err_flags_t           found
);
    logic addr_bad, off_bad, cnt_bad, iter_bad;

    always_comb begin
        addr_bad = not_aligned(dst_addr_lo, dst_size);
        off_bad  = not_aligned(dst_off_lo, dst_size);
        cnt_bad  = not_aligned(nbytes_lo, src_size) | not_aligned(nbytes_lo, dst_size);
        iter_bad = (cur_iter == '0) | (cur_link_en != beg_link_en);

        found          = NO_ERR;
        found.dst_addr = chk_start & addr_bad;
        found.dst_off  = chk_start & off_bad;
        found.cnt_iter = chk_start & (cnt_bad | iter_bad);
    end
endmodule

// File: rtl/sga_rule_eval.sv
module sga_rule_eval
    import dmachk_pkg::*;
(
    input  logic             major_done,
    input  logic             sg_enable,
    input  logic [SGA_W-1:0] sg_addr_lo,
    input  logic             rd_bus_err,
    input  logic             wr_bus_err,
    output err_flags_t       found
);
    always_comb begin
        found         = NO_ERR;
        found.sg_addr = major_done & sg_enable & (sg_addr_lo != '0);
        found.src_bus = rd_bus_err;
        found.dst_bus = wr_bus_err;
    end
endmodule

// File: rtl/err_record.sv
module err_record
    import dmachk_pkg::*;
#(
    parameter int CH_BITS = CHAN_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_w1c,
    input  err_flags_t         evt,
    input  logic [CH_BITS-1:0] chan_id,
    output err_flags_t         flags_q,
    output logic               valid_q,
    output logic [CH_BITS-1:0] chan_q
);
    logic hit;
    assign hit = |evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= NO_ERR;
            valid_q <= 1'b0;
            chan_q  <= '0;
        end else if (hit) begin
            flags_q <= evt;
            valid_q <= 1'b1;
            chan_q  <= chan_id;
        end else if (clr_w1c) begin
            flags_q <= NO_ERR;
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_cfg_err_chk.sv
module dma_cfg_err_chk
    import dmachk_pkg::*;
#(
    parameter int CH_BITS   = CHAN_W,
    parameter int ITER_BITS = ITER_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CH_BITS-1:0]   chan_id,
    input  logic                 chk_start,
    input  logic [1:0]           src_size,
    input  logic [1:0]           dst_size,
    input  logic [LOW_W-1:0]     dst_addr_lo,
    input  logic [LOW_W-1:0]     dst_off_lo,
    input  logic [LOW_W-1:0]     nbytes_lo,
    input  logic [ITER_BITS-1:0] cur_iter,
    input  logic                 cur_link_en,
    input  logic                 beg_link_en,
    input  logic                 major_done,
    input  logic                 sg_enable,
    input  logic [SGA_W-1:0]     sg_addr_lo,
    input  logic                 rd_bus_err,
    input  logic                 wr_bus_err,
    input  logic                 clr_w1c,
    output logic                 err_dst_addr,
    output logic                 err_dst_off,
    output logic                 err_cnt_iter,
    output logic                 err_sg_addr,
    output logic                 err_src_bus,
    output logic                 err_dst_bus,
    output logic                 err_valid,
    output logic [CH_BITS-1:0]   err_chan
);
    err_flags_t desc_found, run_found, evt, flags;

    desc_rule_eval #(.ITER_BITS(ITER_BITS)) u_desc (
        .chk_start   (chk_start),
        .src_size    (xfer_size_e'(src_size)),
        .dst_size    (xfer_size_e'(dst_size)),
        .dst_addr_lo (dst_addr_lo),
        .dst_off_lo  (dst_off_lo),
        .nbytes_lo   (nbytes_lo),
        .cur_iter    (cur_iter),
        .cur_link_en (cur_link_en),
        .beg_link_en (beg_link_en),
        .found       (desc_found)
    );

    sga_rule_eval u_run (
        .major_done (major_done),
        .sg_enable  (sg_enable),
        .sg_addr_lo (sg_addr_lo),
        .rd_bus_err (rd_bus_err),
        .wr_bus_err (wr_bus_err),
        .found      (run_found)
    );

    assign evt = desc_found | run_found;

    err_record #(.CH_BITS(CH_BITS)) u_rec (
        .clk     (clk),
        .rst     (rst),
        .clr_w1c (clr_w1c),
        .evt     (evt),
        .chan_id (chan_id),
        .flags_q (flags),
        .valid_q (err_valid),
        .chan_q  (err_chan)
    );

    assign err_dst_addr = flags.dst_addr;
    assign err_dst_off  = flags.dst_off;
    assign err_cnt_iter = flags.cnt_iter;
    assign err_sg_addr  = flags.sg_addr;
    assign err_src_bus  = flags.src_bus;
    assign err_dst_bus  = flags.dst_bus;
endmodule

// File: rtl/dma_cfg_err_chk_sva.sv
module dma_cfg_err_chk_sva #(
    parameter int CH_BITS   = 6,
    parameter int ITER_BITS = 15
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CH_BITS-1:0]   chan_id,
    input logic                 chk_start,
    input logic [1:0]           src_size,
    input logic [1:0]           dst_size,
    input logic [2:0]           dst_addr_lo,
    input logic [2:0]           dst_off_lo,
    input logic [2:0]           nbytes_lo,
    input logic [ITER_BITS-1:0] cur_iter,
    input logic                 cur_link_en,
    input logic                 beg_link_en,
    input logic                 major_done,
    input logic                 sg_enable,
    input logic [4:0]           sg_addr_lo,
    input logic                 rd_bus_err,
    input logic                 wr_bus_err,
    input logic                 clr_w1c,
    input logic                 err_dst_addr,
    input logic                 err_dst_off,
    input logic                 err_cnt_iter,
    input logic                 err_sg_addr,
    input logic                 err_src_bus,
    input logic                 err_dst_bus,
    input logic                 err_valid,
    input logic [CH_BITS-1:0]   err_chan
);
    logic [2:0] dmask, smask;
    logic       any_evt;
    logic [5:0] flags;

    assign dmask = 3'((4'd1 << dst_size) - 4'd1);
    assign smask = 3'((4'd1 << src_size) - 4'd1);
    assign flags = {err_dst_addr, err_dst_off, err_cnt_iter, err_sg_addr, err_src_bus, err_dst_bus};
    assign any_evt = rd_bus_err | wr_bus_err
                   | (major_done & sg_enable & (sg_addr_lo != 5'd0))
                   | (chk_start & (((dst_addr_lo & dmask) != 3'd0) | ((dst_off_lo & dmask) != 3'd0)
                                   | ((nbytes_lo & (dmask | smask)) != 3'd0)
                                   | (cur_iter == '0) | (cur_link_en != beg_link_en)));

    a_r1_dst_addr: assert property (@(posedge clk) disable iff (rst)
        (chk_start && ((dst_addr_lo & dmask) != 3'd0)) |=> err_dst_addr);

    a_r5_sg_addr: assert property (@(posedge clk) disable iff (rst)
        (major_done && sg_enable && sg_addr_lo != 5'd0) |=> err_sg_addr);

    a_r6_bus: assert property (@(posedge clk) disable iff (rst)
        (rd_bus_err || wr_bus_err) |=> (err_src_bus == $past(rd_bus_err) && err_dst_bus == $past(wr_bus_err)));

    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        any_evt |=> (err_valid && err_chan == $past(chan_id)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!any_evt && !clr_w1c) |=> ($stable(flags) && $stable(err_valid) && $stable(err_chan)));

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_w1c && !any_evt) |=> (!err_valid && flags == 6'd0 && $stable(err_chan)));

    a_r7_vld_flags: assert property (@(posedge clk) disable iff (rst)
        err_valid == (flags != 6'd0));
endmodule

bind dma_cfg_err_chk dma_cfg_err_chk_sva #(.CH_BITS(CH_BITS), .ITER_BITS(ITER_BITS)) u_sva (
    .clk(clk), .rst(rst), .chan_id(chan_id), .chk_start(chk_start),
    .src_size(src_size), .dst_size(dst_size), .dst_addr_lo(dst_addr_lo),
    .dst_off_lo(dst_off_lo), .nbytes_lo(nbytes_lo), .cur_iter(cur_iter),
    .cur_link_en(cur_link_en), .beg_link_en(beg_link_en), .major_done(major_done),
    .sg_enable(sg_enable), .sg_addr_lo(sg_addr_lo), .rd_bus_err(rd_bus_err),
    .wr_bus_err(wr_bus_err), .clr_w1c(clr_w1c), .err_dst_addr(err_dst_addr),
    .err_dst_off(err_dst_off), .err_cnt_iter(err_cnt_iter), .err_sg_addr(err_sg_addr),
    .err_src_bus(err_src_bus), .err_dst_bus(err_dst_bus), .err_valid(err_valid),
    .err_chan(err_chan)
);

// File: tb/dma_cfg_err_chk_tb.sv
module dma_cfg_err_chk_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  chan_id = '0;
    logic        chk_start = 0;
    logic [1:0]  src_size = 2'd2, dst_size = 2'd2;
    logic [2:0]  dst_addr_lo = '0, dst_off_lo = 3'd4, nbytes_lo = '0;
    logic [14:0] cur_iter = 15'd5;
    logic        cur_link_en = 0, beg_link_en = 0;
    logic        major_done = 0, sg_enable = 0;
    logic [4:0]  sg_addr_lo = '0;
    logic        rd_bus_err = 0, wr_bus_err = 0, clr_w1c = 0;
    logic        e_da, e_do, e_ci, e_sg, e_sb, e_db, e_vld;
    logic [5:0]  e_ch;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    dma_cfg_err_chk dut_i (
        .clk(clk), .rst(rst), .chan_id(chan_id), .chk_start(chk_start),
        .src_size(src_size), .dst_size(dst_size), .dst_addr_lo(dst_addr_lo),
        .dst_off_lo(dst_off_lo), .nbytes_lo(nbytes_lo), .cur_iter(cur_iter),
        .cur_link_en(cur_link_en), .beg_link_en(beg_link_en), .major_done(major_done),
        .sg_enable(sg_enable), .sg_addr_lo(sg_addr_lo), .rd_bus_err(rd_bus_err),
        .wr_bus_err(wr_bus_err), .clr_w1c(clr_w1c), .err_dst_addr(e_da),
        .err_dst_off(e_do), .err_cnt_iter(e_ci), .err_sg_addr(e_sg),
        .err_src_bus(e_sb), .err_dst_bus(e_db), .err_valid(e_vld), .err_chan(e_ch)
    );

    // flags order: {dst_addr, dst_off, cnt_iter, sg_addr, src_bus, dst_bus}
    task automatic check(input string req, input logic [5:0] xf, input logic xv, input logic [5:0] xc);
        logic [5:0] af;
        af = {e_da, e_do, e_ci, e_sg, e_sb, e_db};
        checks++;
        if (af !== xf || e_vld !== xv || e_ch !== xc) begin
            errors++;
            $display("FAIL %s: flags=%b valid=%b chan=%0d expected flags=%b valid=%b chan=%0d",
                     req, af, e_vld, e_ch, xf, xv, xc);
        end
    endtask

    task automatic clean_desc();
        src_size = 2'd2; dst_size = 2'd2; dst_addr_lo = 3'd0; dst_off_lo = 3'd4;
        nbytes_lo = 3'd0; cur_iter = 15'd5; cur_link_en = 0; beg_link_en = 0;
    endtask

    task automatic release_strobes();
        chk_start = 0; major_done = 0; sg_enable = 0; rd_bus_err = 0;
        wr_bus_err = 0; clr_w1c = 0; clean_desc();
    endtask

    task automatic t_reset();
        check("R8 reset", 6'b000000, 0, 6'd0);
    endtask

    task automatic t_dst_addr();
        @(negedge clk); clean_desc(); chan_id = 6'd3; dst_addr_lo = 3'd2; chk_start = 1;
        #1 check("R10 before edge", 6'b000000, 0, 6'd0);
        @(negedge clk); release_strobes();
        check("R1 dst addr", 6'b100000, 1, 6'd3);
    endtask

    task automatic t_dst_off();
        @(negedge clk); chan_id = 6'd4; dst_size = 2'd1; dst_off_lo = 3'd3; chk_start = 1;
        @(negedge clk); release_strobes();
        check("R2 dst off / R7 replace", 6'b010000, 1, 6'd4);
    endtask

    task automatic t_cnt();
        @(negedge clk); chan_id = 6'd5; src_size = 2'd3; dst_size = 2'd0; nbytes_lo = 3'd4; chk_start = 1;
        @(negedge clk); release_strobes();
        check("R3 nbytes vs src size", 6'b001000, 1, 6'd5);
        @(negedge clk); chan_id = 6'd6; cur_iter = 15'd0; chk_start = 1;
        @(negedge clk); release_strobes();
        check("R4 zero iteration", 6'b001000, 1, 6'd6);
        @(negedge clk); chan_id = 6'd7; cur_link_en = 1; beg_link_en = 0; chk_start = 1;
        @(negedge clk); release_strobes();
        check("R4 link mismatch", 6'b001000, 1, 6'd7);
    endtask

    task automatic t_clean();
        @(negedge clk); chan_id = 6'd9; chk_start = 1;
        @(negedge clk); release_strobes();
        check("R8 clean descriptor holds", 6'b001000, 1, 6'd7);
    endtask

    task automatic t_sga();
        @(negedge clk); chan_id = 6'd10; major_done = 1; sg_enable = 0; sg_addr_lo = 5'd4;
        @(negedge clk); release_strobes();
        check("R5 chaining off ignored", 6'b001000, 1, 6'd7);
        @(negedge clk); sg_enable = 1; sg_addr_lo = 5'd4;
        @(negedge clk); release_strobes();
        check("R5 no major done ignored", 6'b001000, 1, 6'd7);
        @(negedge clk); major_done = 1; sg_enable = 1; sg_addr_lo = 5'd0;
        @(negedge clk); release_strobes();
        check("R5 aligned address", 6'b001000, 1, 6'd7);
        @(negedge clk); major_done = 1; sg_enable = 1; sg_addr_lo = 5'd8;
        @(negedge clk); release_strobes();
        check("R5 misaligned address", 6'b000100, 1, 6'd10);
    endtask

    task automatic t_bus();
        @(negedge clk); chan_id = 6'd11; rd_bus_err = 1;
        @(negedge clk); release_strobes();
        check("R6 read fault", 6'b000010, 1, 6'd11);
        @(negedge clk); chan_id = 6'd12; wr_bus_err = 1;
        @(negedge clk); release_strobes();
        check("R6 write fault / R7", 6'b000001, 1, 6'd12);
    endtask

    task automatic t_multi();
        @(negedge clk); chan_id = 6'd13; dst_size = 2'd1; dst_addr_lo = 3'd1; dst_off_lo = 3'd1;
        chk_start = 1; rd_bus_err = 1;
        @(negedge clk); release_strobes();
        check("R7 combined same cycle", 6'b110010, 1, 6'd13);
    endtask

    task automatic t_clear();
        @(negedge clk); clr_w1c = 1;
        @(negedge clk); release_strobes();
        check("R9 clear", 6'b000000, 0, 6'd13);
        @(negedge clk); chan_id = 6'd14; clr_w1c = 1; wr_bus_err = 1;
        @(negedge clk); release_strobes();
        check("R9 fault beats clear", 6'b000001, 1, 6'd14);
        @(negedge clk); clr_w1c = 1;
        @(negedge clk); release_strobes();
        @(negedge clk); clr_w1c = 1;
        @(negedge clk); release_strobes();
        check("R9 clear when empty", 6'b000000, 0, 6'd14);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 0;
                @(negedge clk);
                t_reset();
                t_dst_addr();
                t_dst_off();
                t_cnt();
                t_clean();
                t_sga();
                t_bus();
                t_multi();
                t_clear();
                done = 1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
                end
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule